// File: doc/BRIEF.md
# Fixed-Latency Block Memory

This block is the backing store behind a direct-mapped data cache. A requester presents a byte address together with a read or a write strobe. The block captures the request into registers at the clock edge where the strobe is seen. It then drops its ready flag for a fixed busy window. When the window ends, ready rises and stays high until the next request is accepted.

A read returns the whole 128-bit, four-word block that holds the address, so a cache can refill a line in one transfer. A write stores one 32-bit word into that block. The read data output is driven combinationally from the storage array at the captured address, with no output register. The storage is a plain register array with a parameterized number of blocks, and it is cleared by reset. The latency parameter must be at least 2, and the block count must be a power of two.

Top module: `lbm_top`

## Requirements
- R1: While reset is held, and at the first edge after reset is released, ready is high, no access is pending, every stored word is zero, and rdata reads as zero.
- R2: A strobe seen while ready is high is accepted at that edge. Ready is then low for exactly LATENCY-1 cycles and high from the next cycle on, so the access spans LATENCY cycles counting the cycle of acceptance.
- R3: Address, write data and access kind are captured at the accepting edge. Changes to those inputs during the busy window do not alter the access.
- R4: A read or write strobe that arrives while ready is low is ignored. It neither starts an access nor changes the stored data.
- R5: Once ready is high, rdata holds the complete block selected by the captured address bits [4 +: log2(DEPTH)]. Word k of the block (address bits [3:2] equal to k) appears on rdata bits [32k+31:32k].
- R6: Address bits above the block index and address bits [1:0] do not take part in selecting a location. Addresses that differ only in those bits alias to the same word.
- R7: A write stores wdata into word addr[3:2] of the selected block and leaves the other three words of that block unchanged. Once ready returns, rdata shows the updated block.
- R8: When the read and write strobes are both high at an accepting edge, the access is carried out as a write.
- R9: While ready is high and no strobe is asserted, ready stays high and rdata does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 32 | Byte address of the access |
| wdata | input | 32 | Word to be written |
| rdata | output | 128 | Block at the captured address, from the array with no output register |
| ready | output | 1 | High when idle or when the last access has finished |

## Verification
The bench first measures the busy window directly. A design that counted one cycle too many or too few would raise ready early or late against the model. It then sends strobes into the busy window, both a second write to the same block and a changed address. A design that restarted or re-latched on these would corrupt the stored word or the returned block. Further cases cover simultaneous read and write strobes, which a design giving reads priority would turn into a no-op, and addresses that differ only in the upper or lowest bits, which a design that decoded too many address bits would not alias. A long randomized stream, in which strobes are often held for several cycles, is compared on every clock against a behavioural model built on an associative array.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 32;
    localparam int BLK_WORDS = 4;
    localparam int BLK_W     = WORD_W * BLK_WORDS;
    localparam int WSEL_W    = $clog2(BLK_WORDS);
    localparam int OFS_LSB   = 2;                    // byte offset inside a word
    localparam int BLK_LSB   = OFS_LSB + WSEL_W;     // first block address bit
    localparam int BADDR_W   = ADDR_W - BLK_LSB;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  block_t;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    typedef struct packed {
        op_e                op;
        logic [BADDR_W-1:0] blk;
        logic [WSEL_W-1:0]  wsel;
        word_t              wdata;
    } req_t;

    // Build a request from the word-aligned part of the address.
    // A write strobe wins over a read strobe.
    function automatic req_t make_req(input logic wr,
                                      input logic [ADDR_W-1:OFS_LSB] waddr,
                                      input word_t d);
        req_t r;
        r.op    = wr ? OP_WRITE : OP_READ;
        r.blk   = waddr[ADDR_W-1:BLK_LSB];
        r.wsel  = waddr[BLK_LSB-1:OFS_LSB];
        r.wdata = d;
        return r;
    endfunction

endpackage

// File: rtl/lbm_ctrl.sv
module lbm_ctrl
    import lbm_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  req_t req_in,
    output logic ready,
    output req_t req_q,
    output logic commit
);
    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(LATENCY - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] remain;
    logic             accept;

    assign ready  = (remain == '0);
    assign accept = ready && strobe;
    assign commit = (remain == LAST) && (req_q.op == OP_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            req_q  <= '0;
        end else if (accept) begin
            remain <= LOAD;
            req_q  <= req_in;
        end else if (remain != '0) begin
            remain <= remain - LAST;
        end
    end

endmodule

// File: rtl/lbm_array.sv
module lbm_array
    import lbm_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] widx,
    input  logic [WSEL_W-1:0]        wsel,
    input  word_t                    wdata,
    input  logic [$clog2(DEPTH)-1:0] ridx,
    output block_t                   rblk
);
    // One word-wide lane per position in the block.
    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_lane
        word_t lane_mem [DEPTH];
        logic  lane_we;

        assign lane_we = we && (wsel == WSEL_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) begin
                    lane_mem[i] <= '0;
                end
            end else if (lane_we) begin
                lane_mem[widx] <= wdata;
            end
        end

        assign rblk[g*WORD_W +: WORD_W] = lane_mem[ridx];
    end

endmodule

// File: rtl/lbm_top.sv
module lbm_top
    import lbm_pkg::*;
#(
    parameter int LATENCY = 3,
    parameter int DEPTH   = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_en,
    input  logic         wr_en,
    input  logic [31:0]  addr,
    input  logic [31:0]  wdata,
    output logic [127:0] rdata,
    output logic         ready
);
    localparam int IDX_W = $clog2(DEPTH);

    req_t             req_in;
    req_t             req_q;
    logic             commit;
    logic [IDX_W-1:0] idx;
    logic             unused_bits;

    assign req_in = make_req(wr_en, addr[ADDR_W-1:OFS_LSB], wdata);
    assign idx    = req_q.blk[IDX_W-1:0];
    assign unused_bits = ^{addr[OFS_LSB-1:0], req_q.blk[BADDR_W-1:IDX_W]};

    lbm_ctrl #(.LATENCY(LATENCY)) ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .strobe (rd_en | wr_en),
        .req_in (req_in),
        .ready  (ready),
        .req_q  (req_q),
        .commit (commit)
    );

    lbm_array #(.DEPTH(DEPTH)) array_i (
        .clk   (clk),
        .rst   (rst),
        .we    (commit),
        .widx  (idx),
        .wsel  (req_q.wsel),
        .wdata (req_q.wdata),
        .ridx  (idx),
        .rblk  (rdata)
    );

endmodule

// File: rtl/lbm_chk.sv
module lbm_chk #(
    parameter int LATENCY = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         rd_en,
    input logic         wr_en,
    input logic [127:0] rdata,
    input logic         ready
);
    int busy_len;

    always_ff @(posedge clk) begin
        if (rst)                         busy_len <= 0;
        else if (ready && (rd_en || wr_en)) busy_len <= 1;
        else if (!ready)                 busy_len <= busy_len + 1;
    end

    a_r1_ready_after_reset: assert property (@(posedge clk) rst |=> ready);

    a_r2_goes_busy: assert property (@(posedge clk) disable iff (rst)
        (ready && (rd_en || wr_en)) |=> !ready);

    a_r2_window_bound: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (busy_len <= LATENCY - 1));

    a_r2_release: assert property (@(posedge clk) disable iff (rst)
        (!ready && busy_len == LATENCY - 1) |=> ready);

    a_r4_no_restart: assert property (@(posedge clk) disable iff (rst)
        (!ready && busy_len < LATENCY - 1) |=> !ready);

    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (ready && !rd_en && !wr_en) |=> (ready && $stable(rdata)));

endmodule

bind lbm_top lbm_chk #(.LATENCY(LATENCY)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .rdata (rdata),
    .ready (ready)
);

// File: tb/lbm_top_tb_top.sv
module lbm_top_tb_top;
    localparam int LAT   = 3;
    localparam int DEPTH = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rd_en = 1'b0, wr_en = 1'b0;
    logic [31:0]  addr = '0, wdata = '0;
    logic [127:0] rdata;
    logic         ready;

    lbm_top #(.LATENCY(LAT), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    always #5 clk = ~clk;

    // behavioural reference
    logic [31:0] mstore [int];
    bit          m_ready = 1'b1;
    bit          m_live  = 1'b0;
    int          m_left  = 0;
    bit          m_wr    = 1'b0;
    logic [31:0] m_addr  = '0;
    logic [31:0] m_wd    = '0;

    int    n_cmp  = 0;
    int    n_fail = 0;
    string tag    = "R1";
    bit    done   = 1'b0;

    function automatic int slot(logic [31:0] a);
        return int'((a >> 4) % DEPTH) * 4 + int'(a[3:2]);
    endfunction

    function automatic logic [127:0] exp_block(logic [31:0] a);
        logic [127:0] b;
        for (int w = 0; w < 4; w++) begin
            int s;
            s = int'((a >> 4) % DEPTH) * 4 + w;
            b[w*32 +: 32] = mstore.exists(s) ? mstore[s] : 32'h0;
        end
        return b;
    endfunction

    task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge: compare, drive, advance model, wait.
    task automatic step(bit r, bit w, logic [31:0] a, logic [31:0] d);
        if (m_live) begin
            check(ready === m_ready, tag, "ready", {127'b0, ready}, {127'b0, m_ready});
            if (m_ready)
                check(rdata === exp_block(m_addr), tag, "rdata", rdata, exp_block(m_addr));
        end
        rd_en = r; wr_en = w; addr = a; wdata = d;
        if (rst) begin
            m_ready = 1'b1; m_left = 0; m_addr = '0; m_live = 1'b1;
            mstore.delete();
        end else if (m_ready && (r || w)) begin
            m_ready = 1'b0; m_left = LAT - 1; m_addr = a; m_wd = d; m_wr = w;
        end else if (!m_ready) begin
            m_left--;
            if (m_left == 0) begin
                m_ready = 1'b1;
                if (m_wr) mstore[slot(m_addr)] = m_wd;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle_until_ready();
        while (!m_ready) step(1'b0, 1'b0, $urandom, $urandom);
        step(1'b0, 1'b0, $urandom, $urandom);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, '0);
        rst = 1'b0;
        tag = "R1";
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, '0);

        // R2: measure the busy window directly
        tag = "R2";
        step(1'b1, 1'b0, 32'h0000_0040, '0);
        begin
            int k = 0;
            while (ready !== 1'b1 && k < 20) begin
                step(1'b0, 1'b0, '0, '0);
                k++;
            end
            check(k == LAT - 1, "R2", "busy cycles", 128'(k), 128'(LAT - 1));
        end

        // R7: word writes, other words kept
        tag = "R7";
        step(1'b0, 1'b1, 32'h0000_0010, 32'hA1A1_0001); idle_until_ready();
        step(1'b0, 1'b1, 32'h0000_001C, 32'hB2B2_0003); idle_until_ready();
        step(1'b1, 1'b0, 32'h0000_0010, '0);            idle_until_ready();
        check(rdata === {32'hB2B2_0003, 64'h0, 32'hA1A1_0001}, "R7", "block",
              rdata, {32'hB2B2_0003, 64'h0, 32'hA1A1_0001});

        // R3: inputs change during the busy window
        tag = "R3";
        step(1'b0, 1'b1, 32'h0000_0034, 32'hC3C3_0005);
        step(1'b0, 1'b0, 32'h0000_0018, 32'hDEAD_BEEF);
        step(1'b0, 1'b0, 32'h0000_0070, 32'hFFFF_FFFF);
        idle_until_ready();
        check(rdata[63:32] === 32'hC3C3_0005, "R3", "captured word",
              128'(rdata[63:32]), 128'(32'hC3C3_0005));

        // R4: strobes while busy are ignored
        tag = "R4";
        step(1'b0, 1'b1, 32'h0000_0020, 32'h1111_2222);
        step(1'b0, 1'b1, 32'h0000_0024, 32'h3333_4444);
        step(1'b1, 1'b1, 32'h0000_0024, 32'h5555_6666);
        idle_until_ready();
        step(1'b1, 1'b0, 32'h0000_0020, '0); idle_until_ready();
        check(rdata === {96'h0, 32'h1111_2222}, "R4", "busy write dropped",
              rdata, {96'h0, 32'h1111_2222});

        // R8: both strobes -> write
        tag = "R8";
        step(1'b1, 1'b1, 32'h0000_0028, 32'h7777_8888); idle_until_ready();
        check(rdata[95:64] === 32'h7777_8888, "R8", "write wins",
              128'(rdata[95:64]), 128'(32'h7777_8888));

        // R6: aliasing of upper and lowest address bits
        tag = "R6";
        step(1'b1, 1'b0, 32'hABC0_0013, '0); idle_until_ready();
        check(rdata[31:0] === 32'hA1A1_0001, "R6", "alias read",
              128'(rdata[31:0]), 128'(32'hA1A1_0001));
        step(1'b0, 1'b1, 32'h5000_041E, 32'h9999_0000); idle_until_ready();
        step(1'b1, 1'b0, 32'h0000_0010, '0);            idle_until_ready();
        check(rdata[127:96] === 32'h9999_0000, "R6", "alias write",
              128'(rdata[127:96]), 128'(32'h9999_0000));

        // R9: long idle stretch
        tag = "R9";
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, $urandom, $urandom);

        // R5: randomized stream, strobes often held several cycles
        tag = "R5";
        for (int i = 0; i < 4000; i++) begin
            bit r, w;
            logic [31:0] a;
            a = $urandom;
            if ($urandom % 4 == 0) a[9:4] = 6'(i % 8);
            r = ($urandom % 3) == 0;
            w = ($urandom % 3) == 0;
            step(r, w, a, $urandom);
        end
        idle_until_ready();

        done = 1'b1;
        summary();
    end
endmodule